// File: doc/BRIEF.md
# Tunnel Occupancy Jam Monitor

This block keeps a running count of the items inside a tunnel. One sensor watches the entry and one watches the exit. Each sensor reads logic 1 while an item breaks its beam. Each sensor input passes through a synchronizer. Its rising edge then sets a sticky pending latch. The two latches are ORed into one request output. A service stage grants one pending event per clock. An entry adds one to the occupancy and an exit takes one away. Once an event has been counted, that event's latch is cancelled. Servicing then continues on the following cycles until both latches are clear, so events that arrive close together or in the same cycle are never dropped.

An active-low alarm follows the count: it goes low whenever the occupancy is above a threshold, which means a jam. A decrement attempted at zero leaves the count at zero and raises a sticky underflow flag. A synchronous preload lets the count be forced to a chosen value once a jam has been cleared. The reset is asserted asynchronously and released through an internal two-stage synchronizer.

Top module: `tunnel_jam_monitor`

## Requirements
- R1: While reset is asserted and after it is released, occupancy is 0, underflow is 0, alarm_n is 1 and request is 0.
- R2: A rising edge on a sensor input (1 = beam broken) sets that sensor's pending latch. request goes high after the third rising clock edge following the input change. It stays high while either latch is set.
- R3: Each serviced entry event adds one to occupancy and each serviced exit event subtracts one. Each rising edge counts exactly once, whether the sensor stays high for one cycle or for many.
- R4: A latch is cleared only in the cycle its event is counted. With one event pending, occupancy changes and request falls at the fourth clock edge after the input change.
- R5: When both latches are pending together, the entry event is serviced at one edge and the exit event at the next. request stays high until the exit has been counted.
- R6: alarm_n is 0 while occupancy is greater than THRESHOLD (default 4) and 1 otherwise, changing in the same cycle as the count.
- R7: An exit event at occupancy 0 leaves the count at 0 and sets underflow. underflow then stays 1 until reset; preload does not clear it.
- R8: An entry event at the largest count (2^CNT_W-1, 255 by default) leaves the count unchanged.
- R9: With preload_en high at a clock edge, occupancy takes preload_val at that edge. No event is serviced in that cycle, and pending events are kept and serviced afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_sense | input | 1 | Entry beam sensor, 1 while broken |
| exit_sense | input | 1 | Exit beam sensor, 1 while broken |
| preload_en | input | 1 | Synchronous load of the count |
| preload_val | input | CNT_W | Value loaded by preload_en |
| alarm_n | output | 1 | Active-low jam alarm |
| occupancy | output | CNT_W | Items currently in the tunnel |
| underflow | output | 1 | Sticky flag: an exit was seen at zero |
| request | output | 1 | OR of the two pending latches |

## Verification
Single entry pulses and single exit pulses show that the direction of counting is right. A sensor held high for many cycles tells edge counting apart from level counting. Entry and exit arriving in the same cycle show that neither event is lost. Applying that same-cycle pair at a count of zero separates entry-first service from exit-first service, because only exit-first would raise underflow. A preload driven into the cycle where service would happen shows that a pending event is held rather than dropped. Random rounds of entry, exit, both and preload run against a bench model that saturates at both ends, and they also cover the alarm threshold from both sides.

// File: rtl/tjm_pkg.sv
package tjm_pkg;
  typedef enum logic [1:0] {
    SVC_IDLE  = 2'd0,
    SVC_ENTRY = 2'd1,
    SVC_EXIT  = 2'd2
  } svc_t;

  localparam int unsigned SIDE_ENTRY = 0;
  localparam int unsigned SIDE_EXIT  = 1;
  localparam int unsigned NUM_SIDES  = 2;
endpackage

// File: rtl/tjm_sensor_latch.sv
module tjm_sensor_latch #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sense,
  input  logic cancel,
  output logic pending
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic prev_q, prev_d;
  logic pend_q, pend_d;
  logic rise;

  always_comb begin
    sync_d[0] = sense;
    for (int i = 1; i < SYNC_STAGES; i++) sync_d[i] = sync_q[i-1];
    prev_d = sync_q[SYNC_STAGES-1];
    rise   = sync_q[SYNC_STAGES-1] & ~prev_q;
    // a fresh edge wins over a cancel of the event already counted
    pend_d = rise | (pend_q & ~cancel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/tjm_occupancy.sv
module tjm_occupancy
  import tjm_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_entry,
  input  logic             pend_exit,
  input  logic             preload_en,
  input  logic [CNT_W-1:0] preload_val,
  output logic             cancel_entry,
  output logic             cancel_exit,
  output logic [CNT_W-1:0] count,
  output logic             underflow
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  svc_t svc;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic uf_q, uf_d;
  logic cnt_en;

  always_comb begin
    if (preload_en)      svc = SVC_IDLE;
    else if (pend_entry) svc = SVC_ENTRY;
    else if (pend_exit)  svc = SVC_EXIT;
    else                 svc = SVC_IDLE;
  end

  assign cancel_entry = (svc == SVC_ENTRY);
  assign cancel_exit  = (svc == SVC_EXIT);

  always_comb begin
    cnt_d  = cnt_q;
    uf_d   = uf_q;
    cnt_en = preload_en || (svc != SVC_IDLE);
    if (preload_en) begin
      cnt_d = preload_val;
    end else begin
      case (svc)
        SVC_ENTRY: if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        SVC_EXIT: begin
          if (cnt_q == '0) uf_d = 1'b1;
          else             cnt_d = cnt_q - 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      uf_q  <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      uf_q  <= uf_d;
    end
  end

  assign count     = cnt_q;
  assign underflow = uf_q;
endmodule

// File: rtl/tunnel_jam_monitor.sv
module tunnel_jam_monitor
  import tjm_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned THRESHOLD   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             entry_sense,
  input  logic             exit_sense,
  input  logic             preload_en,
  input  logic [CNT_W-1:0] preload_val,
  output logic             alarm_n,
  output logic [CNT_W-1:0] occupancy,
  output logic             underflow,
  output logic             request
);
  localparam logic [CNT_W-1:0] THRESH_V = CNT_W'(THRESHOLD);

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [NUM_SIDES-1:0] sense_vec, cancel_vec, pend_vec;
  logic cancel_entry, cancel_exit;

  assign sense_vec[SIDE_ENTRY]  = entry_sense;
  assign sense_vec[SIDE_EXIT]   = exit_sense;
  assign cancel_vec[SIDE_ENTRY] = cancel_entry;
  assign cancel_vec[SIDE_EXIT]  = cancel_exit;

  for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
    tjm_sensor_latch #(.SYNC_STAGES(SYNC_STAGES)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .sense   (sense_vec[g]),
      .cancel  (cancel_vec[g]),
      .pending (pend_vec[g])
    );
  end

  tjm_occupancy #(.CNT_W(CNT_W)) u_occ (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .pend_entry   (pend_vec[SIDE_ENTRY]),
    .pend_exit    (pend_vec[SIDE_EXIT]),
    .preload_en   (preload_en),
    .preload_val  (preload_val),
    .cancel_entry (cancel_entry),
    .cancel_exit  (cancel_exit),
    .count        (occupancy),
    .underflow    (underflow)
  );

  assign request = |pend_vec;
  assign alarm_n = ~(occupancy > THRESH_V);
endmodule

// File: rtl/tjm_checker.sv
module tjm_checker #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned THRESHOLD = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             preload_en,
  input logic [CNT_W-1:0] preload_val,
  input logic             pend_entry,
  input logic             pend_exit,
  input logic             request,
  input logic             alarm_n,
  input logic [CNT_W-1:0] occupancy,
  input logic             underflow
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] THRESH_V = CNT_W'(THRESHOLD);

  assert_step_of_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !preload_en |=> (occupancy == $past(occupancy)) ||
      ({1'b0, occupancy} == {1'b0, $past(occupancy)} + 1'b1) ||
      ({1'b0, occupancy} == {1'b0, $past(occupancy)} - 1'b1));

  assert_idle_holds_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!request && !preload_en) |=> $stable(occupancy));

  assert_exit_waits_for_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_entry && pend_exit && !preload_en) |=> pend_exit && request);

  assert_alarm_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_n == !(occupancy > THRESH_V));

  assert_underflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  assert_no_wrap_at_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (occupancy == CNT_MAX && !preload_en) |=> occupancy >= CNT_MAX - 1'b1);

  assert_preload_loads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    preload_en |=> occupancy == $past(preload_val));
endmodule

bind tunnel_jam_monitor tjm_checker #(.CNT_W(CNT_W), .THRESHOLD(THRESHOLD)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_int),
  .preload_en  (preload_en),
  .preload_val (preload_val),
  .pend_entry  (pend_vec[0]),
  .pend_exit   (pend_vec[1]),
  .request     (request),
  .alarm_n     (alarm_n),
  .occupancy   (occupancy),
  .underflow   (underflow)
);

// File: tb/tunnel_jam_monitor_test.sv
`timescale 1ns/1ps
module tunnel_jam_monitor_test;
  localparam int CW = 8;
  localparam int MAXV = 255;

  logic clk = 1'b0;
  logic rst_n;
  logic entry_sense, exit_sense, preload_en;
  logic [CW-1:0] preload_val;
  logic alarm_n, underflow, request;
  logic [CW-1:0] occupancy;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int m_cnt;
  bit m_uf;

  always #2.5 clk = ~clk;

  tunnel_jam_monitor uut (
    .clk(clk), .rst_n(rst_n), .entry_sense(entry_sense), .exit_sense(exit_sense),
    .preload_en(preload_en), .preload_val(preload_val), .alarm_n(alarm_n),
    .occupancy(occupancy), .underflow(underflow), .request(request)
  );

  function automatic int exp_alarm_n(int c);
    return (c > 4) ? 0 : 1;
  endfunction

  function automatic int model_entry(int c);
    return (c == MAXV) ? c : c + 1;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nstep(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_state(string tag);
    check({tag, " occupancy"}, int'(occupancy), m_cnt);
    check({tag, " alarm_n R6"}, int'(alarm_n), exp_alarm_n(m_cnt));
    check({tag, " underflow R7"}, int'(underflow), int'(m_uf));
    check({tag, " request idle R4"}, int'(request), 0);
  endtask

  // one round: pulse chosen sensors for one cycle, then settle
  task automatic round(bit e, bit x);
    entry_sense = e; exit_sense = x;
    nstep(1);
    entry_sense = 1'b0; exit_sense = 1'b0;
    nstep(8);
    if (e) m_cnt = model_entry(m_cnt);
    if (x) begin
      if (m_cnt == 0) m_uf = 1'b1;
      else m_cnt = m_cnt - 1;
    end
  endtask

  task automatic preload(int v);
    preload_en = 1'b1; preload_val = CW'(v);
    nstep(1);
    preload_en = 1'b0;
    m_cnt = v;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    check("R1 occupancy in reset", int'(occupancy), 0);
    check("R1 underflow in reset", int'(underflow), 0);
    nstep(3);
    rst_n = 1'b1;
    nstep(4);
    m_cnt = 0; m_uf = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    entry_sense = 1'b0; exit_sense = 1'b0; preload_en = 1'b0; preload_val = '0;
    void'($urandom(32'd20240611));
    nstep(1);
    do_reset();
    check("R1 occupancy", int'(occupancy), 0);
    check("R1 underflow", int'(underflow), 0);
    check("R1 alarm_n", int'(alarm_n), 1);
    check("R1 request", int'(request), 0);

    // R2 / R4 latency of a single entry pulse
    entry_sense = 1'b1; nstep(1); entry_sense = 1'b0;
    nstep(1);
    check("R2 request not yet", int'(request), 0);
    nstep(1);
    check("R2 request raised", int'(request), 1);
    check("R4 count before service", int'(occupancy), 0);
    nstep(1);
    check("R3 entry adds one", int'(occupancy), 1);
    check("R4 request cleared after service", int'(request), 0);
    m_cnt = 1;

    // R3 long hold counts once
    entry_sense = 1'b1; nstep(12); entry_sense = 1'b0; nstep(8);
    m_cnt = 2;
    check("R3 long hold counted once", int'(occupancy), 2);

    // R5 both in the same cycle
    entry_sense = 1'b1; exit_sense = 1'b1; nstep(1);
    entry_sense = 1'b0; exit_sense = 1'b0;
    nstep(2);
    check("R5 both pending request", int'(request), 1);
    check("R5 count before", int'(occupancy), 2);
    nstep(1);
    check("R5 entry first", int'(occupancy), 3);
    check("R5 exit still pending", int'(request), 1);
    nstep(1);
    check("R5 exit next", int'(occupancy), 2);
    check("R5 request drops", int'(request), 0);

    // R3 exits down to zero, R5 ordering at zero, R7 underflow
    round(0, 1); round(0, 1);
    check_state("R3 exits to zero");
    round(1, 1);
    check_state("R5 pair at zero no underflow");
    round(0, 1);
    check("R7 underflow set", int'(underflow), 1);
    check("R7 count held at zero", int'(occupancy), 0);
    round(1, 0);
    check_state("R7 underflow stays");

    // R6 threshold boundary
    preload(4); nstep(1);
    check("R6 at four alarm_n", int'(alarm_n), 1);
    round(1, 0);
    check("R6 at five alarm_n", int'(alarm_n), 0);
    round(0, 1);
    check("R6 back to four alarm_n", int'(alarm_n), 1);

    // R9 preload keeps underflow, R8 saturation at max
    preload(MAXV); nstep(1);
    check("R9 preload value", int'(occupancy), MAXV);
    check("R7 preload keeps underflow", int'(underflow), 1);
    round(1, 0);
    check_state("R8 entry at max");

    // R9 preload in the service cycle holds the event
    preload(10);
    entry_sense = 1'b1; nstep(1); entry_sense = 1'b0;
    nstep(2);
    preload_en = 1'b1; preload_val = CW'(20);
    nstep(1);
    preload_en = 1'b0;
    check("R9 preload wins service cycle", int'(occupancy), 20);
    check("R9 event still pending", int'(request), 1);
    nstep(1);
    check("R9 held event serviced after", int'(occupancy), 21);
    m_cnt = 21;
    nstep(4);

    // random rounds
    for (int i = 0; i < 300; i++) begin
      int r;
      r = int'($urandom_range(0, 15));
      if (r == 0) begin
        preload(int'($urandom_range(0, 9)));
        nstep(2);
      end else if (r < 6) round(1, 0);
      else if (r < 11) round(0, 1);
      else round(1, 1);
      check_state("R3 random round");
    end

    // R1 / R7 reset clears underflow
    preload(7); nstep(1);
    do_reset();
    check("R1 reset clears count", int'(occupancy), 0);
    check("R7 reset clears underflow", int'(underflow), 0);
    check("R1 reset alarm_n", int'(alarm_n), 1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule